// File: doc/BRIEF.md
# Coin-Operated Vending Controller

This block is the control core of a small vending machine. It offers five products and takes three coin denominations. It keeps a running total of the money inserted and compares that total with the price of the product currently selected. Once the money covers the price, it issues a dispense strobe and works out the change. The coin mechanism supplies one-cycle pulses. Display drivers downstream take the four BCD digits and turn them into segments.

The block is a Moore machine: every output is decoded from registered state only. While the machine is collecting coins, the left pair of digits shows the total inserted and the right pair shows the price. A sale has two phases, a one-cycle dispense state and a hold phase whose length is a parameter. Through both phases the left pair shows the change and the right pair shows 00. The machine then returns to collecting with a total of zero. An asynchronous, active-high reset clears the machine at any moment.

Top module: `vend_ctrl`

## Requirements
- R1: While `rst` is high, and without waiting for a clock edge, the machine is in its collecting state with a zero total, selection register 0, `dispense`=0, `change_cents`=0 and `disp_digits`=16'h0055.
- R2: The coin inputs carry the following values: `coin_25` is worth 25 cents, `coin_10` is worth 10 and `coin_5` is worth 5. While collecting, a pulse adds its value to the total at that clock edge. `sel` is registered at every edge while collecting. Product k (k = 0 to 4) costs 55+5k cents. During collecting, `disp_digits` is {total tens, total units, price tens, price units}, one BCD nibble each, most significant nibble first.
- R3: When more than one coin input is high in the same cycle, only one coin is counted: 25 takes priority over 10, and 10 over 5.
- R4: The total saturates at 95 cents and never goes above it.
- R5: Select codes 5, 6 and 7 show a price of 00 and never cause a dispense, whatever the total.
- R6: At the first edge where the machine is collecting, the registered selection is valid and the total is at least its price, the machine enters the dispense state. `dispense` is then 1 for exactly one cycle, and the change is the total minus the price.
- R7: From the dispense cycle through the HOLD_CYCLES cycles that follow, `change_cents` holds the change and `disp_digits` shows {change tens, change units, 0, 0}.
- R8: After the hold phase the machine returns to collecting with a zero total. Coin pulses seen at the edges that leave the dispense state or the hold cycles are not counted.
- R9: Every BCD units digit shown is 0 or 5, and every digit is in the range 0 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| sel | input | 3 | Product select code, valid values 0 to 4 |
| coin_25 | input | 1 | One-cycle pulse for a 25-cent coin |
| coin_10 | input | 1 | One-cycle pulse for a 10-cent coin |
| coin_5 | input | 1 | One-cycle pulse for a 5-cent coin |
| dispense | output | 1 | One-cycle dispense strobe |
| change_cents | output | 7 | Change in cents during the dispense and hold phases, otherwise 0 |
| disp_digits | output | 16 | Four BCD digits, left to right from the most significant nibble |

## Verification
The bench drives a total that lands exactly on the price, where zero change still has to trigger a sale. A design with a strict comparison would never dispense in that case. It presses two coins at once to expose a wrong priority order or coins summed together, and it drives an invalid selection up to the 95-cent ceiling, where a missing clamp shows a wrapped or oversized total. It pulses coins during the hold phase, and a design that leaks them shows a non-zero total on return. It also counts the hold cycles, which catches a counter that is one cycle off or a dispense strobe that lasts longer than one cycle.

// File: rtl/vend_pkg.sv
package vend_pkg;

    localparam int CENTS_W    = 7;
    localparam int SEL_W      = 3;
    localparam int N_PRODUCTS = 5;
    localparam int BASE_PRICE = 55;
    localparam int PRICE_STEP = 5;
    localparam int TOTAL_MAX  = 95;

    typedef logic [CENTS_W-1:0] cents_t;

    typedef enum logic [1:0] {
        ST_COLLECT = 2'd0,
        ST_VEND    = 2'd1,
        ST_HOLD    = 2'd2
    } vend_state_t;

    typedef struct packed {
        logic [3:0] tens;
        logic [3:0] units;
    } bcd2_t;

    function automatic logic sel_valid(input logic [SEL_W-1:0] s);
        return int'(s) < N_PRODUCTS;
    endfunction

    function automatic cents_t price_of(input logic [SEL_W-1:0] s);
        if (sel_valid(s))
            return cents_t'(BASE_PRICE + PRICE_STEP * int'(s));
        return '0;
    endfunction

    function automatic bcd2_t to_bcd(input cents_t v);
        bcd2_t r;
        r.tens  = 4'(v / cents_t'(10));
        r.units = 4'(v % cents_t'(10));
        return r;
    endfunction

    function automatic cents_t coin_pick(input logic c25, input logic c10,
                                         input logic c5);
        if (c25) return cents_t'(25);
        if (c10) return cents_t'(10);
        if (c5)  return cents_t'(5);
        return '0;
    endfunction

endpackage

// File: rtl/vend_coin_accum.sv
module vend_coin_accum
    import vend_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   accept,
    input  logic   clear,
    input  logic   c25,
    input  logic   c10,
    input  logic   c5,
    output cents_t total
);

    localparam int SUM_W = CENTS_W + 1;

    logic [SUM_W-1:0] sum;
    cents_t           next_total;

    always_comb begin
        sum = {1'b0, total} + {1'b0, coin_pick(c25, c10, c5)};
        if (sum > SUM_W'(TOTAL_MAX))
            next_total = cents_t'(TOTAL_MAX);
        else
            next_total = sum[CENTS_W-1:0];
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst)
            total <= '0;
        else if (clear)
            total <= '0;
        else if (accept)
            total <= next_total;
    end

    assert_total_ceiling_R4: assert property (@(posedge clk) disable iff (rst)
        total <= cents_t'(TOTAL_MAX));

    assert_total_step_R9: assert property (@(posedge clk) disable iff (rst)
        (total % cents_t'(5)) == '0);

endmodule

// File: rtl/vend_fsm.sv
module vend_fsm
    import vend_pkg::*;
#(
    parameter int HOLD_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  cents_t      total,
    input  cents_t      price,
    input  logic        price_ok,
    output vend_state_t state,
    output cents_t      change,
    output logic        accept_coin,
    output logic        clear_total
);

    localparam int HCW = $clog2(HOLD_CYCLES + 1);
    localparam logic [HCW-1:0] HOLD_LOAD = HCW'(HOLD_CYCLES - 1);

    logic [HCW-1:0] hold_cnt;
    logic           vend_now;

    always_comb begin
        vend_now    = (state == ST_COLLECT) && price_ok && (total >= price);
        accept_coin = (state == ST_COLLECT) && !vend_now;
        clear_total = vend_now;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state    <= ST_COLLECT;
            change   <= '0;
            hold_cnt <= '0;
        end else begin
            case (state)
                ST_COLLECT: begin
                    if (vend_now) begin
                        state  <= ST_VEND;
                        change <= total - price;
                    end
                end
                ST_VEND: begin
                    state    <= ST_HOLD;
                    hold_cnt <= HOLD_LOAD;
                end
                ST_HOLD: begin
                    if (hold_cnt == '0)
                        state <= ST_COLLECT;
                    else
                        hold_cnt <= hold_cnt - 1'b1;
                end
                default: state <= ST_COLLECT;
            endcase
        end
    end

    assert_bad_select_no_vend_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_COLLECT && !price_ok) |=> (state == ST_COLLECT));

    assert_vend_then_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_VEND) |=> (state == ST_HOLD));

endmodule

// File: rtl/vend_display.sv
module vend_display
    import vend_pkg::*;
(
    input  vend_state_t state,
    input  cents_t      total,
    input  cents_t      price,
    input  cents_t      change,
    output logic [15:0] digits,
    output cents_t      change_out
);

    bcd2_t left_f;
    bcd2_t right_f;

    always_comb begin
        if (state == ST_COLLECT) begin
            left_f     = to_bcd(total);
            right_f    = to_bcd(price);
            change_out = '0;
        end else begin
            left_f     = to_bcd(change);
            right_f    = '0;
            change_out = change;
        end
        digits = {left_f, right_f};
    end

endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
    import vend_pkg::*;
#(
    parameter int HOLD_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  sel,
    input  logic        coin_25,
    input  logic        coin_10,
    input  logic        coin_5,
    output logic        dispense,
    output logic [6:0]  change_cents,
    output logic [15:0] disp_digits
);

    logic [SEL_W-1:0] sel_q;
    vend_state_t      state;
    cents_t           total;
    cents_t           change;
    cents_t           price;
    logic             price_ok;
    logic             accept_coin;
    logic             clear_total;

    always_ff @(posedge clk or posedge rst) begin
        if (rst)
            sel_q <= '0;
        else if (state == ST_COLLECT)
            sel_q <= sel;
    end

    always_comb begin
        price    = price_of(sel_q);
        price_ok = sel_valid(sel_q);
        dispense = (state == ST_VEND);
    end

    vend_coin_accum i_accum (
        .clk    (clk),
        .rst    (rst),
        .accept (accept_coin),
        .clear  (clear_total),
        .c25    (coin_25),
        .c10    (coin_10),
        .c5     (coin_5),
        .total  (total)
    );

    vend_fsm #(.HOLD_CYCLES(HOLD_CYCLES)) i_fsm (
        .clk         (clk),
        .rst         (rst),
        .total       (total),
        .price       (price),
        .price_ok    (price_ok),
        .state       (state),
        .change      (change),
        .accept_coin (accept_coin),
        .clear_total (clear_total)
    );

    vend_display i_disp (
        .state      (state),
        .total      (total),
        .price      (price),
        .change     (change),
        .digits     (disp_digits),
        .change_out (change_cents)
    );

    assert_single_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        dispense |=> !dispense);

    assert_units_digits_R9: assert property (@(posedge clk) disable iff (rst)
        (disp_digits[3:0] == 4'd0 || disp_digits[3:0] == 4'd5) &&
        (disp_digits[11:8] == 4'd0 || disp_digits[11:8] == 4'd5));

endmodule

// File: tb/test_vend_ctrl.sv
`timescale 1ns/1ps
module test_vend_ctrl;

    localparam int H = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  sel = 3'd0;
    logic        coin_25 = 1'b0;
    logic        coin_10 = 1'b0;
    logic        coin_5 = 1'b0;
    logic        dispense;
    logic [6:0]  change_cents;
    logic [15:0] disp_digits;

    int errors = 0;
    int checks = 0;
    bit run = 0;

    // behavioural reference state
    int m_state = 0;   // 0 collecting, 1 dispensing, 2 holding
    int m_total = 0;
    int m_sel = 0;
    int m_change = 0;
    int m_hold = 0;

    always #10 clk = ~clk;

    vend_ctrl #(.HOLD_CYCLES(H)) i_vend_ctrl (
        .clk          (clk),
        .rst          (rst),
        .sel          (sel),
        .coin_25      (coin_25),
        .coin_10      (coin_10),
        .coin_5       (coin_5),
        .dispense     (dispense),
        .change_cents (change_cents),
        .disp_digits  (disp_digits)
    );

    function automatic int ref_price(int s);
        if (s >= 0 && s <= 4) return 55 + 5 * s;
        return 0;
    endfunction

    function automatic int pair(int v);
        return ((v / 10) << 4) | (v % 10);
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk or posedge rst) begin
        if (rst) begin
            m_state = 0; m_total = 0; m_sel = 0; m_change = 0; m_hold = 0;
        end else begin
            case (m_state)
                0: begin
                    if (m_sel <= 4 && m_total >= ref_price(m_sel)) begin
                        m_change = m_total - ref_price(m_sel);
                        m_total = 0;
                        m_state = 1;
                    end else begin
                        if (coin_25) m_total += 25;
                        else if (coin_10) m_total += 10;
                        else if (coin_5) m_total += 5;
                        if (m_total > 95) m_total = 95;
                    end
                    m_sel = int'(sel);
                end
                1: begin m_state = 2; m_hold = H - 1; end
                default: begin
                    if (m_hold == 0) m_state = 0;
                    else m_hold--;
                end
            endcase
        end
    end

    // per-cycle comparison against the reference
    always @(posedge clk) begin
        #5;
        if (run) begin
            check("R6 dispense vs model", int'(dispense), int'(m_state == 1));
            check("R7 change vs model", int'(change_cents), (m_state != 0) ? m_change : 0);
            if (m_state == 0)
                check("R2 digits vs model", int'(disp_digits),
                      (pair(m_total) << 8) | pair(ref_price(m_sel)));
            else
                check("R7 digits vs model", int'(disp_digits), pair(m_change) << 8);
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drop(logic a, logic b, logic c);
        coin_25 = a; coin_10 = b; coin_5 = c;
        @(negedge clk);
        coin_25 = 0; coin_10 = 0; coin_5 = 0;
    endtask

    task automatic choose(logic [2:0] s);
        sel = s;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        tick(2);
        check("R1 reset digits", int'(disp_digits), 16'h0055);
        check("R1 reset dispense", int'(dispense), 0);
        check("R1 reset change", int'(change_cents), 0);
        rst = 0;
        run = 1;

        // exact price, zero change
        choose(3'd0);
        check("R2 price 55", int'(disp_digits), 16'h0055);
        drop(1, 0, 0);
        check("R2 total 25", int'(disp_digits), 16'h2555);
        drop(1, 0, 0);
        check("R2 total 50", int'(disp_digits), 16'h5055);
        drop(0, 0, 1);
        check("R2 total 55", int'(disp_digits), 16'h5555);
        check("R6 no early dispense", int'(dispense), 0);
        tick(1);
        check("R6 dispense exact", int'(dispense), 1);
        check("R6 zero change", int'(change_cents), 0);
        check("R7 change shown 00", int'(disp_digits), 16'h0000);
        tick(1);
        check("R6 strobe one cycle", int'(dispense), 0);
        tick(H);
        check("R8 back to collect", int'(disp_digits), 16'h0055);

        // change of 10, hold timing, coins ignored while holding
        choose(3'd4);
        check("R2 price 75", int'(disp_digits), 16'h0075);
        drop(1, 0, 0);
        drop(1, 0, 0);
        drop(0, 1, 0);
        check("R2 total 60", int'(disp_digits), 16'h6075);
        drop(1, 0, 0);
        check("R9 total 85 bcd", int'(disp_digits), 16'h8575);
        tick(1);
        check("R6 dispense 85", int'(dispense), 1);
        check("R6 change 10", int'(change_cents), 10);
        check("R7 change digits", int'(disp_digits), 16'h1000);
        for (int i = 0; i < H; i++) begin
            if (i == 0) drop(1, 1, 1);
            else drop(0, 1, 0);
            check("R7 change held", int'(change_cents), 10);
            check("R7 change digits held", int'(disp_digits), 16'h1000);
            check("R6 no repeat strobe", int'(dispense), 0);
        end
        tick(1);
        check("R8 total cleared, hold coins ignored", int'(disp_digits), 16'h0075);

        // priority
        drop(1, 0, 1);
        check("R3 25 over 5", int'(disp_digits), 16'h2575);
        drop(0, 1, 1);
        check("R3 10 over 5", int'(disp_digits), 16'h3575);
        drop(1, 1, 1);
        check("R3 25 over all", int'(disp_digits), 16'h6075);

        // asynchronous reset mid-cycle
        rst = 1;
        #2;
        check("R1 async digits", int'(disp_digits), 16'h0055);
        check("R1 async dispense", int'(dispense), 0);
        @(negedge clk);
        rst = 0;

        // invalid select and saturation
        choose(3'd7);
        check("R5 price 00 for 7", int'(disp_digits), 16'h0000);
        drop(1, 0, 0);
        drop(1, 0, 0);
        drop(1, 0, 0);
        check("R5 total 75 no vend", int'(disp_digits), 16'h7500);
        drop(1, 0, 0);
        check("R4 clamp 95", int'(disp_digits), 16'h9500);
        drop(0, 0, 1);
        check("R4 stays 95", int'(disp_digits), 16'h9500);
        for (int i = 0; i < 3; i++) begin
            tick(1);
            check("R5 never dispense", int'(dispense), 0);
        end
        choose(3'd0);
        check("R2 price after reselect", int'(disp_digits), 16'h9555);
        tick(1);
        check("R6 dispense from 95", int'(dispense), 1);
        check("R6 change 40", int'(change_cents), 40);
        check("R7 digits 40", int'(disp_digits), 16'h4000);
        tick(H + 1);
        check("R8 cleared after 95", int'(disp_digits), 16'h0055);

        choose(3'd5);
        check("R5 price 00 for 5", int'(disp_digits), 16'h0000);
        choose(3'd6);
        check("R5 price 00 for 6", int'(disp_digits), 16'h0000);
        drop(0, 0, 1);
        check("R9 units 5", int'(disp_digits), 16'h0500);
        tick(2);
        summary();
    end

endmodule